// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single compare channel that sits beside a timer counter. Each clock it receives the counter's present value, the counting direction, the reload limit, a count-advance strobe and the update event. From these it builds a registered reference waveform whose shape is set by a three-bit mode field. The reference can be frozen, set or cleared on a match, toggled on a match, forced to either level, or turned into a pulse-width waveform of either sense.

The reference reaches the pin through a polarity choice and a channel enable. The compare value is written through a small port. It either lands at once or waits in a shadow register until the next update event. A sticky match flag records compare hits. In center-aligned operation only hits in the chosen counting direction set it. The flag drives an interrupt line through an enable.

Top module: `oc_channel`

## Requirements
- R1: While reset is asserted and until the synchronised reset releases, `ref_o` is 0, `flag_o` is 0, `cmp_o` is 0 and `pin_o` sits at its inactive level.
- R2: With `mode_i` = 0 (frozen), `ref_o` keeps its value whatever the count does.
- R3: With `mode_i` = 1, `ref_o` goes to 1 on the clock after a match event; with `mode_i` = 2 it goes to 0. A match event is `tick_i` high with `cnt_i` equal to `cmp_o`. Without a match event `ref_o` holds.
- R4: With `mode_i` = 3, `ref_o` inverts on the clock after each match event and holds otherwise.
- R5: With `mode_i` = 4, `ref_o` is 0 on the next clock; with `mode_i` = 5 it is 1, whatever the count.
- R6: With `mode_i` = 6 and `down_i` = 0, `ref_o` on the next clock is 1 when `cnt_i` < `cmp_o` and 0 otherwise. With `down_i` = 1 it is 0 when `cnt_i` > `cmp_o` and 1 otherwise. `mode_i` = 7 gives the inverse level in both directions.
- R7: In mode 6, a compare value above `reload_i` keeps `ref_o` at 1 even for counts above the reload value (0 in mode 7).
- R8: `pin_o` equals `ref_o` XOR `pol_i` while `en_i` = 1. While `en_i` = 0, `pin_o` equals `pol_i`, the inactive level.
- R9: With `preload_i` = 0, a write (`wr_i`) appears on `cmp_o` on the next clock. With `preload_i` = 1 the write goes to a shadow register, and `cmp_o` changes only on a clock where `upd_i` is 1. On that clock it takes the shadow value, or the data written in that same cycle.
- R10: A match event sets the flag according to `align_i`. Value 0 (edge-aligned) sets it in either direction, 1 only when counting down, 2 only when counting up, 3 in both directions.
- R11: The flag stays set until `clr_i`, and a set in the same cycle wins over the clear. `irq_o` equals `flag_o` AND `irq_en_i`.
- R12: While `tick_i` = 0, an equal count is not a match event. Modes 1 to 3 and the flag ignore it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | W | Current counter value |
| down_i | input | 1 | Counter direction, 1 = counting down |
| reload_i | input | W | Counter reload limit |
| tick_i | input | 1 | Counter advanced this cycle |
| upd_i | input | 1 | Update event |
| align_i | input | 2 | Flag direction qualifier: 0 edge, 1 down, 2 up, 3 both |
| mode_i | input | 3 | Reference mode 0..7 |
| pol_i | input | 1 | 1 = active-low pin |
| en_i | input | 1 | Channel output enable |
| preload_i | input | 1 | Compare preload enable |
| wr_i | input | 1 | Compare write strobe |
| wdata_i | input | W | Compare write data |
| clr_i | input | 1 | Clear the match flag |
| irq_en_i | input | 1 | Interrupt enable |
| cmp_o | output | W | Active compare value |
| ref_o | output | 1 | Reference signal |
| pin_o | output | 1 | Polarity-adjusted, enabled output |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check several rules on every cycle. The forced levels and the frozen hold are checked. So are the immediate and the held-off compare loads, the stickiness of the flag, and the rule that no flag rises without a count strobe. Set, clear and toggle on a match, the PWM levels in each direction, the reload corner and the direction filter on the flag are shown by the bench scenarios. The bench compares every output each cycle against a model built from the requirements, under random stimulus and directed cases.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_FROZEN  = 3'd0,
    OC_SET     = 3'd1,
    OC_CLEAR   = 3'd2,
    OC_TOGGLE  = 3'd3,
    OC_FORCE_L = 3'd4,
    OC_FORCE_H = 3'd5,
    OC_PWM_A   = 3'd6,
    OC_PWM_B   = 3'd7
  } oc_mode_e;

  typedef enum logic [1:0] {
    AL_EDGE = 2'd0,
    AL_DOWN = 2'd1,
    AL_UP   = 2'd2,
    AL_BOTH = 2'd3
  } oc_align_e;
endpackage

// File: rtl/oc_cmp_reg.sv
module oc_cmp_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         preload_i,
  input  logic         upd_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cmp_o
);
  logic [W-1:0] act_q, act_d, shd_q, shd_d;
  logic         act_en;

  always_comb begin
    shd_d  = wr_i ? wdata_i : shd_q;
    act_en = preload_i ? upd_i : wr_i;
    act_d  = preload_i ? shd_d : wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      shd_q <= '0;
    end else begin
      if (wr_i)   shd_q <= shd_d;
      if (act_en) act_q <= act_d;
    end
  end

  assign cmp_o = act_q;

  p_direct_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !preload_i) |=> (cmp_o == $past(wdata_i)));
  p_preload_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_i && !upd_i) |=> $stable(cmp_o));
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  oc_mode_e     mode_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] reload_i,
  input  logic         down_i,
  input  logic         hit_i,
  output logic         ref_o
);
  logic ref_q, ref_d, pwm_lvl, beyond;

  always_comb begin
    beyond  = cmp_i > reload_i;
    pwm_lvl = beyond | (down_i ? (cnt_i <= cmp_i) : (cnt_i < cmp_i));
    unique case (mode_i)
      OC_FROZEN:  ref_d = ref_q;
      OC_SET:     ref_d = hit_i ? 1'b1 : ref_q;
      OC_CLEAR:   ref_d = hit_i ? 1'b0 : ref_q;
      OC_TOGGLE:  ref_d = hit_i ? ~ref_q : ref_q;
      OC_FORCE_L: ref_d = 1'b0;
      OC_FORCE_H: ref_d = 1'b1;
      OC_PWM_A:   ref_d = pwm_lvl;
      OC_PWM_B:   ref_d = ~pwm_lvl;
      default:    ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_d;
  end

  assign ref_o = ref_q;

  p_force_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OC_FORCE_L) |=> !ref_o);
  p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OC_FORCE_H) |=> ref_o);
  p_frozen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OC_FROZEN) |=> (ref_o == $past(ref_o)));
endmodule

// File: rtl/oc_match_flag.sv
module oc_match_flag
  import oc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit_i,
  input  logic      tick_i,
  input  logic      down_i,
  input  oc_align_e align_i,
  input  logic      clr_i,
  output logic      flag_o
);
  logic flag_q, flag_d, dir_ok;

  always_comb begin
    unique case (align_i)
      AL_DOWN: dir_ok = down_i;
      AL_UP:   dir_ok = ~down_i;
      default: dir_ok = 1'b1;
    endcase
    if (hit_i && dir_ok) flag_d = 1'b1;
    else if (clr_i)      flag_d = 1'b0;
    else                 flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  p_no_tick_no_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !flag_o) |=> !flag_o);
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int W      = 16,
  parameter int SYNC_N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic         down_i,
  input  logic [W-1:0] reload_i,
  input  logic         tick_i,
  input  logic         upd_i,
  input  logic [1:0]   align_i,
  input  logic [2:0]   mode_i,
  input  logic         pol_i,
  input  logic         en_i,
  input  logic         preload_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  input  logic         irq_en_i,
  output logic [W-1:0] cmp_o,
  output logic         ref_o,
  output logic         pin_o,
  output logic         flag_o,
  output logic         irq_o
);
  localparam int SL = (SYNC_N < 1) ? 1 : SYNC_N;

  logic [SL-1:0] sync_q;
  logic          rst_s_n;
  logic          hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SL-2:0], 1'b1};
  end
  assign rst_s_n = sync_q[SL-1];

  assign hit = tick_i && (cnt_i == cmp_o);

  oc_cmp_reg #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_s_n), .preload_i(preload_i), .upd_i(upd_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .cmp_o(cmp_o)
  );

  oc_ref_gen #(.W(W)) u_ref (
    .clk(clk), .rst_n(rst_s_n), .mode_i(oc_mode_e'(mode_i)), .cnt_i(cnt_i),
    .cmp_i(cmp_o), .reload_i(reload_i), .down_i(down_i), .hit_i(hit),
    .ref_o(ref_o)
  );

  oc_match_flag u_flag (
    .clk(clk), .rst_n(rst_s_n), .hit_i(hit), .tick_i(tick_i), .down_i(down_i),
    .align_i(oc_align_e'(align_i)), .clr_i(clr_i), .flag_o(flag_o)
  );

  assign pin_o = en_i ? (ref_o ^ pol_i) : pol_i;
  assign irq_o = flag_o & irq_en_i;
endmodule

// File: tb/sim_oc_channel.sv
module sim_oc_channel;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cnt_i = '0, reload_i = 16'd12, wdata_i = '0;
  logic down_i = 0, tick_i = 0, upd_i = 0, pol_i = 0, en_i = 0;
  logic preload_i = 0, wr_i = 0, clr_i = 0, irq_en_i = 0;
  logic [1:0] align_i = 0;
  logic [2:0] mode_i = 0;
  logic [W-1:0] cmp_o;
  logic ref_o, pin_o, flag_o, irq_o;

  int checks = 0, errors = 0;
  logic [W-1:0] m_act = '0, m_shd = '0;
  logic m_ref = 0, m_flag = 0;

  always #10 clk = ~clk;

  oc_channel #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .down_i(down_i), .reload_i(reload_i),
    .tick_i(tick_i), .upd_i(upd_i), .align_i(align_i), .mode_i(mode_i),
    .pol_i(pol_i), .en_i(en_i), .preload_i(preload_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .clr_i(clr_i), .irq_en_i(irq_en_i), .cmp_o(cmp_o),
    .ref_o(ref_o), .pin_o(pin_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string ref_tag(logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Expected next state from the requirements
  task automatic model_step();
    logic evt, pwm, qual;
    evt = tick_i && (cnt_i == m_act);
    pwm = (m_act > reload_i) || (down_i ? (cnt_i <= m_act) : (cnt_i < m_act));
    case (mode_i)
      3'd1: if (evt) m_ref = 1'b1;
      3'd2: if (evt) m_ref = 1'b0;
      3'd3: if (evt) m_ref = ~m_ref;
      3'd4: m_ref = 1'b0;
      3'd5: m_ref = 1'b1;
      3'd6: m_ref = pwm;
      3'd7: m_ref = ~pwm;
      default: ;
    endcase
    qual = (align_i == 2'd1) ? down_i : (align_i == 2'd2) ? !down_i : 1'b1;
    if (evt && qual) m_flag = 1'b1;
    else if (clr_i)  m_flag = 1'b0;
    if (preload_i) begin
      if (upd_i) m_act = wr_i ? wdata_i : m_shd;
    end else if (wr_i) m_act = wdata_i;
    if (wr_i) m_shd = wdata_i;
  endtask

  task automatic check_all();
    chk(ref_tag(mode_i), {15'd0, ref_o}, {15'd0, m_ref});
    chk("R8", {15'd0, pin_o}, {15'd0, en_i ? (m_ref ^ pol_i) : pol_i});
    chk(align_i == 2'd0 ? "R11" : "R10", {15'd0, flag_o}, {15'd0, m_flag});
    chk("R11", {15'd0, irq_o}, {15'd0, m_flag & irq_en_i});
    chk("R9", cmp_o, m_act);
  endtask

  // Apply one cycle of inputs: check present outputs first
  task automatic cyc(logic [2:0] md, logic [W-1:0] c, logic dn, logic tk,
                     logic w, logic [W-1:0] wd, logic pl, logic up,
                     logic [1:0] al, logic cl);
    @(negedge clk);
    check_all();
    mode_i = md; cnt_i = c; down_i = dn; tick_i = tk; wr_i = w; wdata_i = wd;
    preload_i = pl; upd_i = up; align_i = al; clr_i = cl;
    model_step();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {15'd0, ref_o}, 16'd0);
    chk("R1", {15'd0, flag_o}, 16'd0);
    chk("R1", cmp_o, 16'd0);
    chk("R1", {15'd0, pin_o}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", cmp_o, 16'd0);

    en_i = 1; irq_en_i = 1;
    // R9: preload holds write until update
    cyc(3'd0, 0, 0, 0, 1, 16'd5, 1, 0, 0, 0);
    cyc(3'd0, 0, 0, 0, 0, 16'd0, 1, 0, 0, 0);
    @(negedge clk); chk("R9", cmp_o, 16'd0);
    cyc(3'd0, 0, 0, 0, 0, 16'd0, 1, 1, 0, 0);
    cyc(3'd0, 0, 0, 0, 0, 16'd0, 0, 0, 0, 0);
    @(negedge clk); chk("R9", cmp_o, 16'd5);
    // R4/R12: toggle, no event without tick
    cyc(3'd3, 16'd5, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(3'd3, 16'd5, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); chk("R12", {15'd0, ref_o}, 16'd0);
    chk("R12", {15'd0, flag_o}, 16'd0);
    cyc(3'd3, 16'd5, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc(3'd0, 16'd5, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); chk("R4", {15'd0, ref_o}, 16'd1);
    // R10: down-only flag ignores up-count hit
    cyc(3'd0, 16'd5, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc(3'd0, 16'd5, 0, 1, 0, 0, 0, 0, 2'd1, 0);
    cyc(3'd0, 16'd5, 0, 0, 0, 0, 0, 0, 2'd1, 0);
    @(negedge clk); chk("R10", {15'd0, flag_o}, 16'd0);
    // R11: set wins over clear
    cyc(3'd0, 16'd5, 1, 1, 0, 0, 0, 0, 2'd1, 1);
    cyc(3'd0, 16'd5, 1, 0, 0, 0, 0, 0, 2'd1, 0);
    @(negedge clk); chk("R11", {15'd0, flag_o}, 16'd1);
    // R7: compare above reload keeps PWM active past reload
    cyc(3'd0, 0, 0, 0, 1, 16'd20, 0, 0, 0, 1);
    cyc(3'd6, 16'd15, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc(3'd6, 16'd15, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); chk("R7", {15'd0, ref_o}, 16'd1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 50) == 0) begin
        pol_i = 1'($urandom); en_i = 1'($urandom); irq_en_i = 1'($urandom);
      end
      cyc(3'($urandom), W'($urandom % 16), 1'($urandom), ($urandom % 4) != 0,
          ($urandom % 8) == 0, W'($urandom % 19), 1'($urandom),
          ($urandom % 6) == 0, 2'($urandom), ($urandom % 10) == 0);
    end
    @(negedge clk);
    check_all();
    finish_run();
  end
endmodule